// File: doc/BRIEF.md
# Flash Byte-Program Pulse Sequencer

This block is a host-side controller that writes a contiguous range of bytes into an older parallel flash device. It uses a pulse-and-verify retry loop. A start request carries a first and a last address. The block raises the high programming voltage and waits for it to settle. It then pulls one data byte at a time from a ready/valid stream and drives the device's command protocol until each byte reads back correctly.

Every attempt on a byte has four steps: a set-up command write, an address/data write, a timed program pulse, and a verify command write. After a timed settle, the block reads the byte back and compares it with the expected value. A byte that does not verify is pulsed again, up to a fixed limit. The whole run ends in one of two ways. On success, the device is returned to read mode, the voltage is dropped and `done_o` pulses. On failure, the voltage is dropped and `err_o` pulses together with the address that would not program.

Both waits are derived from a clock-frequency parameter and rounded up, so neither is ever shorter than required. All bus writes use a strobe of fixed length, with address and data held steady around it.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `f_we_n_o`=1, `f_oe_n_o`=1, `vpp_hi_o`=0, `done_o`=0, `err_o`=0.
- R2: When a run starts, `vpp_hi_o` rises and at least RAMP_CYC cycles pass before the first write strobe. At the end, `vpp_hi_o` falls and at least RAMP_CYC cycles pass before `done_o` or `err_o`.
- R3: Each attempt on a byte writes 0x40 on the data bus, then writes the target data at the target address, then writes 0xC0. No other command is written between them.
- R4: The verify strobe (0xC0) starts no earlier than ceil(CLK_KHZ*10/1000) cycles after the address/data strobe ends. `f_oe_n_o` falls no earlier than ceil(CLK_KHZ*6/1000) cycles after the verify strobe ends.
- R5: The byte read while `f_oe_n_o`=0 is compared with the expected byte. On a match the address advances by one, and the next byte is taken from the stream when `data_rdy_o` and `data_vld_i` are both high.
- R6: On a mismatch the same byte is pulsed again without fetching new data. The per-byte pulse count starts from zero for each byte and never exceeds MAX_PULSES (25).
- R7: If a byte still mismatches after its MAX_PULSES-th pulse, the run aborts without a read-mode command. `err_o` then pulses for one cycle with `res_addr_o` equal to that byte's address, and later bytes are not touched.
- R8: After the last byte verifies, 0x00 is written. Then, after the ramp-down wait, `done_o` pulses for one cycle with `res_addr_o` equal to the end address.
- R9: Every write holds `f_we_n_o` low for exactly WE_CYC cycles. `f_addr_o` and `f_dq_o` are stable from the strobe's falling edge through the first cycle after it, with `f_dq_oe_o`=1 and `f_oe_n_o`=1.
- R10: `start_i` is taken only while `busy_o`=0. A start raised during a run changes neither its outcome nor any other address.
- R11: `f_we_n_o` and `f_oe_n_o` are never low together, and `vpp_hi_o` is 1 whenever `f_we_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted while idle |
| start_addr_i | input | ADDR_W | First address of the range |
| end_addr_i | input | ADDR_W | Last address of the range |
| data_rdy_o | output | 1 | Block wants the byte for `f_addr_o` |
| data_vld_i | input | 1 | Byte on `data_i` is valid |
| data_i | input | DATA_W | Byte to program |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse: range programmed |
| err_o | output | 1 | One-cycle pulse: pulse limit reached |
| res_addr_o | output | ADDR_W | Last or failing address |
| f_addr_o | output | ADDR_W | Flash address bus |
| f_dq_o | output | DATA_W | Flash data out |
| f_dq_oe_o | output | 1 | Data bus drive enable |
| f_dq_i | input | DATA_W | Flash data in |
| f_we_n_o | output | 1 | Flash write enable, active low |
| f_oe_n_o | output | 1 | Flash output enable, active low |
| vpp_hi_o | output | 1 | Select high programming voltage |

## Verification
The flash model programs a byte only after a number of pulses set per address. The bench tries ranges where every byte takes one pulse, which shows the basic address walk and the final read-mode command. It tries a range with bytes needing 3 and exactly 25 pulses, which separates correct retry counting from an off-by-one at the limit. A byte needing 26 pulses, alone and in the middle of a range, shows the abort path: the failing address is reported, the read command is skipped, and later bytes stay untouched. A start raised mid-run shows that requests are ignored while busy.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RAMP_UP,
    S_FETCH,
    S_SETUP_WR,
    S_PGM_WR,
    S_PGM_WAIT,
    S_VFY_WR,
    S_VFY_WAIT,
    S_READ,
    S_CMP,
    S_RDCMD_WR,
    S_RAMP_DN
  } seq_st_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_SET,
    W_STB,
    W_HLD
  } wr_st_e;

  localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
  localparam logic [7:0] CMD_PGM_VFY   = 8'h C0;
  localparam logic [7:0] CMD_READ_MODE = 8'h00;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fseq_wstrobe.sv
module fseq_wstrobe
  import fseq_pkg::*;
#(
  parameter int WE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic we_n_o,
  output logic done_o
);

  localparam int CW = $clog2(WE_CYC + 1);

  wr_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      W_IDLE: if (go_i) st_d = W_SET;
      W_SET: begin
        cnt_d = CW'(WE_CYC - 1);
        st_d  = W_STB;
      end
      W_STB: begin
        if (cnt_q == '0) st_d = W_HLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      W_HLD: st_d = go_i ? W_SET : W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign we_n_o = (st_q != W_STB);
  assign done_o = (st_q == W_HLD);

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_KHZ    = 50000,
  parameter int PGM_US     = 10,
  parameter int VFY_US     = 6,
  parameter int RAMP_CYC   = 5000,
  parameter int WE_CYC     = 4,
  parameter int RD_CYC     = 3,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic              data_rdy_o,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic [ADDR_W-1:0] f_addr_o,
  output logic [DATA_W-1:0] f_dq_o,
  output logic              f_dq_oe_o,
  input  logic [DATA_W-1:0] f_dq_i,
  output logic              f_we_n_o,
  output logic              f_oe_n_o,
  output logic              vpp_hi_o
);

  localparam int PGM_CYC = ceil_div(CLK_KHZ * PGM_US, 1000);
  localparam int VFY_CYC = ceil_div(CLK_KHZ * VFY_US, 1000);
  localparam int TMR_M1  = (RAMP_CYC > PGM_CYC) ? RAMP_CYC : PGM_CYC;
  localparam int TMR_M2  = (VFY_CYC > RD_CYC) ? VFY_CYC : RD_CYC;
  localparam int TMR_MAX = (TMR_M1 > TMR_M2) ? TMR_M1 : TMR_M2;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PCNT_W  = $clog2(MAX_PULSES + 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_sn   <= rst_s1_q;
    end
  end

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, end_q, end_d;
  logic [DATA_W-1:0] wdat_q, wdat_d, rd_q, rd_d;
  logic [PCNT_W-1:0] pls_q, pls_d;
  logic              fail_q, fail_d;
  logic              done_q, done_d, err_q, err_d;
  logic              tmr_ld, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              wr_go, wr_done, wr_we_n;

  fseq_timer #(.W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fseq_wstrobe #(.WE_CYC(WE_CYC)) u_wr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .go_i   (wr_go),
    .we_n_o (wr_we_n),
    .done_o (wr_done)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    end_d   = end_q;
    wdat_d  = wdat_q;
    rd_d    = rd_q;
    pls_d   = pls_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    wr_go   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          cur_d   = start_addr_i;
          end_d   = end_addr_i;
          fail_d  = 1'b0;
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(RAMP_CYC);
          st_d    = S_RAMP_UP;
        end
      end
      S_RAMP_UP: if (tmr_zero) st_d = S_FETCH;
      S_FETCH: begin
        if (data_vld_i) begin
          wdat_d = data_i;
          pls_d  = '0;
          wr_go  = 1'b1;
          st_d   = S_SETUP_WR;
        end
      end
      S_SETUP_WR: begin
        if (wr_done) begin
          wr_go = 1'b1;
          st_d  = S_PGM_WR;
        end
      end
      S_PGM_WR: begin
        if (wr_done) begin
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(PGM_CYC);
          st_d    = S_PGM_WAIT;
        end
      end
      S_PGM_WAIT: begin
        if (tmr_zero) begin
          wr_go = 1'b1;
          st_d  = S_VFY_WR;
        end
      end
      S_VFY_WR: begin
        if (wr_done) begin
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(VFY_CYC);
          st_d    = S_VFY_WAIT;
        end
      end
      S_VFY_WAIT: begin
        if (tmr_zero) begin
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(RD_CYC - 1);
          st_d    = S_READ;
        end
      end
      S_READ: begin
        if (tmr_zero) begin
          rd_d = f_dq_i;
          st_d = S_CMP;
        end
      end
      S_CMP: begin
        if (rd_q == wdat_q) begin
          if (cur_q == end_q) begin
            wr_go = 1'b1;
            st_d  = S_RDCMD_WR;
          end else begin
            cur_d = cur_q + 1'b1;
            st_d  = S_FETCH;
          end
        end else begin
          pls_d = pls_q + 1'b1;
          if (pls_q == PCNT_W'(MAX_PULSES - 1)) begin
            fail_d  = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = TMR_W'(RAMP_CYC);
            st_d    = S_RAMP_DN;
          end else begin
            wr_go = 1'b1;
            st_d  = S_SETUP_WR;
          end
        end
      end
      S_RDCMD_WR: begin
        if (wr_done) begin
          tmr_ld  = 1'b1;
          tmr_val = TMR_W'(RAMP_CYC);
          st_d    = S_RAMP_DN;
        end
      end
      S_RAMP_DN: begin
        if (tmr_zero) begin
          done_d = !fail_q;
          err_d  = fail_q;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      end_q  <= '0;
      wdat_q <= '0;
      rd_q   <= '0;
      pls_q  <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      end_q  <= end_d;
      wdat_q <= wdat_d;
      rd_q   <= rd_d;
      pls_q  <= pls_d;
      fail_q <= fail_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // bus drive
  logic wr_phase;
  assign wr_phase = (st_q == S_SETUP_WR) || (st_q == S_PGM_WR) ||
                    (st_q == S_VFY_WR)   || (st_q == S_RDCMD_WR);

  always_comb begin
    case (st_q)
      S_SETUP_WR: f_dq_o = DATA_W'(CMD_PGM_SETUP);
      S_VFY_WR:   f_dq_o = DATA_W'(CMD_PGM_VFY);
      S_RDCMD_WR: f_dq_o = DATA_W'(CMD_READ_MODE);
      default:    f_dq_o = wdat_q;
    endcase
  end

  assign f_addr_o   = cur_q;
  assign f_dq_oe_o  = wr_phase;
  assign f_we_n_o   = wr_we_n;
  assign f_oe_n_o   = (st_q != S_READ);
  assign vpp_hi_o   = (st_q != S_IDLE) && (st_q != S_RAMP_DN);
  assign busy_o     = (st_q != S_IDLE);
  assign data_rdy_o = (st_q == S_FETCH);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign res_addr_o = cur_q;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int PGM_CYC    = 500,
  parameter int VFY_CYC    = 300,
  parameter int RAMP_CYC   = 5000,
  parameter int MAX_PULSES = 25,
  parameter int PCNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] f_addr_o,
  input logic [DATA_W-1:0] f_dq_o,
  input logic              f_dq_oe_o,
  input logic              f_we_n_o,
  input logic              f_oe_n_o,
  input logic              vpp_hi_o,
  input logic [PCNT_W-1:0] pls_q
);

  localparam int CW = $clog2(RAMP_CYC + PGM_CYC + VFY_CYC + 8);
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [DATA_W-1:0] VFY_CODE = DATA_W'(8'hC0);

  logic          we_prv;
  logic [CW-1:0] we_gap, vpp_on, vpp_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prv  <= 1'b1;
      we_gap  <= '0;
      vpp_on  <= '0;
      vpp_off <= '0;
    end else begin
      we_prv <= f_we_n_o;
      if (f_we_n_o && !we_prv) we_gap <= '0;
      else if (we_gap != SAT)  we_gap <= we_gap + 1'b1;
      if (!vpp_hi_o)           vpp_on <= '0;
      else if (vpp_on != SAT)  vpp_on <= vpp_on + 1'b1;
      if (vpp_hi_o)            vpp_off <= '0;
      else if (vpp_off != SAT) vpp_off <= vpp_off + 1'b1;
    end
  end

  a_r11_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!f_we_n_o && !f_oe_n_o));

  a_r11_vpp_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !f_we_n_o |-> vpp_hi_o);

  a_r9_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_we_n_o && !$past(f_we_n_o)) |-> ($stable(f_addr_o) && $stable(f_dq_o) && f_dq_oe_o));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_we_n_o) |-> ($stable(f_addr_o) && $stable(f_dq_o) && f_dq_oe_o));

  a_r4_pgm_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(f_we_n_o) && f_dq_o == VFY_CODE) |-> (we_gap >= CW'(PGM_CYC)));

  a_r4_vfy_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_oe_n_o) |-> (we_gap >= CW'(VFY_CYC)));

  a_r2_ramp_up: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_we_n_o) |-> (vpp_on >= CW'(RAMP_CYC)));

  a_r2_ramp_down: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (!vpp_hi_o && vpp_off >= CW'(RAMP_CYC)));

  a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  a_r8_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);

  a_r6_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    pls_q <= PCNT_W'(MAX_PULSES));

endmodule

bind flash_pgm_seq fseq_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PGM_CYC    (PGM_CYC),
  .VFY_CYC    (VFY_CYC),
  .RAMP_CYC   (RAMP_CYC),
  .MAX_PULSES (MAX_PULSES),
  .PCNT_W     (PCNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .f_addr_o  (f_addr_o),
  .f_dq_o    (f_dq_o),
  .f_dq_oe_o (f_dq_oe_o),
  .f_we_n_o  (f_we_n_o),
  .f_oe_n_o  (f_oe_n_o),
  .vpp_hi_o  (vpp_hi_o),
  .pls_q     (pls_q)
);

// File: tb/sim_flash_pgm_seq.sv
module sim_flash_pgm_seq;

  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int KHZ  = 20000;
  localparam int RAMP = 50;
  localparam int WEC  = 3;
  localparam int RDC  = 2;
  localparam int MAXP = 25;
  localparam int PGM_EXP = (KHZ * 10 + 999) / 1000;
  localparam int VFY_EXP = (KHZ * 6 + 999) / 1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0, end_addr_i = '0;
  logic          data_rdy_o, data_vld_i = 1'b0;
  logic [DW-1:0] data_i;
  logic          busy_o, done_o, err_o;
  logic [AW-1:0] res_addr_o, f_addr_o;
  logic [DW-1:0] f_dq_o, f_dq_i;
  logic          f_dq_oe_o, f_we_n_o, f_oe_n_o, vpp_hi_o;

  flash_pgm_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .PGM_US(10), .VFY_US(6),
    .RAMP_CYC(RAMP), .WE_CYC(WEC), .RD_CYC(RDC), .MAX_PULSES(MAXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .start_addr_i(start_addr_i), .end_addr_i(end_addr_i),
    .data_rdy_o(data_rdy_o), .data_vld_i(data_vld_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .res_addr_o(res_addr_o),
    .f_addr_o(f_addr_o), .f_dq_o(f_dq_o), .f_dq_oe_o(f_dq_oe_o), .f_dq_i(f_dq_i),
    .f_we_n_o(f_we_n_o), .f_oe_n_o(f_oe_n_o), .vpp_hi_o(vpp_hi_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return DW'((int'(a) * 29 + 5) & 8'h7F);
  endfunction

  function automatic int need_of(input int a);
    case (a)
      8'h21:   return 3;
      8'h22:   return 25;
      8'h30:   return 26;
      8'h42:   return 26;
      default: return 1;
    endcase
  endfunction

  // flash model and bus monitor
  logic [DW-1:0] mem [256];
  int pulses [256];
  int tot_pulses = 0, rdcmd_cnt = 0, seq_err = 0, outcomes = 0;
  int mode = 0, last_pgm_rise = 0, last_vfy_rise = 0, vpp_rise = 0, vpp_fall = 0;
  int stb_len = 0;
  bit stb_bad = 0, first_wr = 0;
  logic we_p = 1'b1, oe_p = 1'b1, vpp_p = 1'b0;
  logic [AW-1:0] stb_a;
  logic [DW-1:0] stb_d;

  assign f_dq_i = f_oe_n_o ? '0 : mem[f_addr_o];
  assign data_i = pat(f_addr_o);

  always @(negedge clk) begin
    cyc++;
    data_vld_i = rst_n && data_rdy_o;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mem[i] = 8'hFF;
        pulses[i] = 0;
      end
      mode = 0;
    end else begin
      if (vpp_hi_o && !vpp_p) begin vpp_rise = cyc; first_wr = 1; end
      if (!vpp_hi_o && vpp_p) vpp_fall = cyc;
      if (!f_we_n_o && we_p) begin
        if (first_wr) begin
          chk(cyc - vpp_rise >= RAMP, "R2", "ramp-up before first strobe", cyc - vpp_rise, RAMP);
          first_wr = 0;
        end
        chk(vpp_hi_o && f_oe_n_o, "R11", "vpp high and oe off at strobe", {vpp_hi_o, f_oe_n_o}, 3);
        if (f_dq_o == 8'hC0)
          chk(cyc - last_pgm_rise >= PGM_EXP, "R4", "program pulse time", cyc - last_pgm_rise, PGM_EXP);
        stb_a = f_addr_o; stb_d = f_dq_o; stb_len = 1; stb_bad = 0;
      end else if (!f_we_n_o) begin
        stb_len++;
        if (f_addr_o != stb_a || f_dq_o != stb_d || !f_dq_oe_o) stb_bad = 1;
      end
      if (f_we_n_o && !we_p) begin
        chk(!stb_bad && stb_len == WEC && f_addr_o == stb_a && f_dq_o == stb_d && f_dq_oe_o,
            "R9", "strobe length/stability", stb_len, WEC);
        if (mode == 1) begin
          pulses[f_addr_o]++;
          tot_pulses++;
          if (pulses[f_addr_o] >= need_of(int'(f_addr_o))) mem[f_addr_o] = f_dq_o;
          last_pgm_rise = cyc;
          mode = 3;
        end else begin
          case (f_dq_o)
            8'h40: mode = 1;
            8'hC0: begin
              if (mode != 3) seq_err++;
              mode = 2;
              last_vfy_rise = cyc;
            end
            8'h00: begin rdcmd_cnt++; mode = 0; end
            default: seq_err++;
          endcase
        end
      end
      if (!f_oe_n_o && oe_p) begin
        if (mode == 2)
          chk(cyc - last_vfy_rise >= VFY_EXP, "R4", "verify settle time", cyc - last_vfy_rise, VFY_EXP);
        else seq_err++;
      end
    end
    we_p = f_we_n_o; oe_p = f_oe_n_o; vpp_p = vpp_hi_o;
  end

  // scoreboard
  typedef struct { bit err; int addr; } exp_t;
  exp_t expq[$];

  always @(negedge clk) begin
    if (rst_n && (done_o || err_o)) begin
      exp_t e;
      if (expq.size() == 0) begin
        chk(0, "R8", "unexpected end pulse", 1, 0);
      end else begin
        e = expq.pop_front();
        chk(err_o == e.err && done_o == !e.err, e.err ? "R7" : "R8", "outcome (err)", err_o, e.err);
        chk(int'(res_addr_o) == e.addr, e.err ? "R7" : "R8", "result address", res_addr_o, e.addr);
        chk(!vpp_hi_o && cyc - vpp_fall >= RAMP, "R2", "ramp-down before end", cyc - vpp_fall, RAMP);
      end
      outcomes++;
    end
  end

  task automatic run(input int s, input int e, input bit exp_err, input int exp_addr,
                     input int exp_pls, input int exp_rd, input bit poke);
    int base_o, base_p, base_r, base_s;
    exp_t x;
    @(posedge clk);
    base_o = outcomes; base_p = tot_pulses; base_r = rdcmd_cnt; base_s = seq_err;
    x.err = exp_err; x.addr = exp_addr;
    expq.push_back(x);
    #1 start_addr_i = AW'(s); end_addr_i = AW'(e); start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    @(negedge clk);
    chk(busy_o, "R10", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (300) @(posedge clk);
      #1 start_addr_i = 8'h60; end_addr_i = 8'h60; start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
    end
    wait (outcomes == base_o + 1);
    @(negedge clk);
    chk(tot_pulses - base_p == exp_pls, "R6", "program pulses in run", tot_pulses - base_p, exp_pls);
    chk(rdcmd_cnt - base_r == exp_rd, exp_rd ? "R8" : "R7", "read-mode commands", rdcmd_cnt - base_r, exp_rd);
    chk(seq_err == base_s, "R3", "command order errors", seq_err - base_s, 0);
    chk(!busy_o, "R10", "idle after end", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && f_we_n_o && f_oe_n_o && !vpp_hi_o && !done_o && !err_o, "R1", "idle outputs",
        {busy_o, f_we_n_o, f_oe_n_o, vpp_hi_o, done_o, err_o}, 6'b011000);

    // R5: all bytes verify on first pulse
    run(8'h10, 8'h13, 0, 8'h13, 4, 1, 0);
    for (int a = 8'h10; a <= 8'h13; a++)
      chk(mem[a] == pat(AW'(a)), "R5", "programmed byte", mem[a], pat(AW'(a)));

    // R6: retries, including exactly MAX pulses
    run(8'h20, 8'h22, 0, 8'h22, 29, 1, 0);
    chk(pulses[8'h21] == 3, "R6", "pulses at 0x21", pulses[8'h21], 3);
    chk(pulses[8'h22] == 25, "R6", "pulses at limit byte", pulses[8'h22], 25);
    chk(mem[8'h22] == pat(8'h22), "R6", "limit byte programmed", mem[8'h22], pat(8'h22));

    // R7: single byte that never verifies
    run(8'h30, 8'h30, 1, 8'h30, 25, 0, 0);
    chk(mem[8'h30] == 8'hFF, "R7", "failed byte unchanged", mem[8'h30], 8'hFF);

    // R7: failure mid-range stops the walk
    run(8'h40, 8'h43, 1, 8'h42, 27, 0, 0);
    chk(mem[8'h41] == pat(8'h41), "R7", "byte before failure", mem[8'h41], pat(8'h41));
    chk(pulses[8'h43] == 0 && mem[8'h43] == 8'hFF, "R7", "byte after failure untouched", pulses[8'h43], 0);

    // R10: start during a run is ignored
    run(8'h50, 8'h51, 0, 8'h51, 2, 1, 1);
    chk(pulses[8'h60] == 0 && mem[8'h60] == 8'hFF, "R10", "poked address untouched", pulses[8'h60], 0);
    chk(mem[8'h51] == pat(8'h51), "R5", "second byte of range", mem[8'h51], pat(8'h51));

    repeat (5) @(negedge clk);
    chk(expq.size() == 0 && outcomes == 5, "R8", "end pulses seen", outcomes, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule